// File: doc/BRIEF.md
# Interleaved Grøstl P/Q Permutation Datapath

This block computes the two 512-bit Grøstl-256 permutations, P and Q, on two independent blocks at once. Each block is held as eight 64-bit columns of eight bytes. A 64-bit datapath handles one column per cycle and is split into two halves. The front half adds the round constant and inverts each byte in GF(2^8). The back half gathers a column along the diagonal of the whole block, which performs the row shift. It then applies the S-box affine map and the column mix. In every 8-cycle slot, one block is in the front half while the other block is in the back half, so P and Q run interleaved.

A host loads the P input (chaining value XOR message) and the Q input (the message) with a start strobe. After a fixed number of cycles it reads both results on a one-cycle done pulse. Combining the two results into the next chaining value is done outside this block.

Top module: `gst_perm`

## Requirements
- R1: While rstN is low, done is 0 and pOut and qOut are all zeros.
- R2: pOut equals ten P rounds applied to pIn. The 512-bit vector is read MSB first: byte k is row (k mod 8) of column (k div 8). Each round has four steps, in this order:
  - XOR the round index (0..9) into row 0 of column 0.
  - Replace every byte with its S-box value: the GF(2^8) inverse modulo x^8+x^4+x^3+x+1 (0 maps to 0), followed by the affine map with constant 0x63.
  - Set new[row i][col j] = old[row i][col (j+i) mod 8].
  - Multiply each column by the circulant matrix whose row r is (02,02,03,04,05,03,05,07) rotated right by r.
- R3: qOut equals ten Q rounds applied to qIn. Q rounds are identical to P rounds except for the constant step: the round index XOR 0xFF goes into row 7 of column 0.
- R4: done is high for exactly one cycle, 168 rising edges after the edge that accepts start. This is (2·ROUNDS+1)·8 cycles.
- R5: From done until the next accepted start, pOut and qOut hold their values, and changes on pIn or qIn have no effect.
- R6: A start pulse, with new inputs, that arrives while a computation is running is ignored. The running results and the done timing are unchanged.
- R7: A start present in the same cycle that done is high is accepted, which allows back-to-back computations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load pIn/qIn and begin when idle |
| pIn | input | 512 | P permutation input block |
| qIn | input | 512 | Q permutation input block |
| pOut | output | 512 | P permutation result |
| qOut | output | 512 | Q permutation result |
| done | output | 1 | One-cycle pulse when both results are valid |

## Verification
Both results and done are due together, 168 rising edges after the edge that samples start. The bench drives start on a falling edge and counts the 168 following falling edges, checking that done stays low throughout. At the 168th falling edge it compares done, pOut and qOut against a bench-side model that builds its own S-box by brute-force inversion. One falling edge later it checks that done has dropped. A few cycles after that it checks that the outputs still hold. Stray start pulses are placed either mid-run or in the done cycle itself. The timing check that follows shows whether each one was ignored or accepted.

// File: rtl/gst_pkg.sv
package gst_pkg;
  localparam int RowCnt   = 8;
  localparam int ColCnt   = 8;
  localparam int ByteW    = 8;
  localparam int ColW     = RowCnt * ByteW;
  localparam int BlkW     = ColCnt * ColW;
  localparam int ColIdxW  = $clog2(ColCnt);
  localparam logic [ByteW-1:0] RedPoly  = 8'h1b;
  localparam logic [ByteW-1:0] AffConst = 8'h63;

  typedef logic [ByteW-1:0] byteT;
  typedef logic [0:RowCnt-1][ByteW-1:0] colT;
  typedef logic [0:ColCnt-1][0:RowCnt-1][ByteW-1:0] blkT;

  // strobes from control to datapath
  typedef struct packed {
    logic               load;
    logic               s1En;
    logic               s1Q;
    byteT               rnd;
    logic               s2En;
    logic               s2Q;
    logic [ColIdxW-1:0] col;
  } ctlT;

  function automatic byteT gfDbl(input byteT a);
    return {a[ByteW-2:0], 1'b0} ^ (a[ByteW-1] ? RedPoly : '0);
  endfunction

  function automatic byteT gfMul(input byteT a, input byteT b);
    byteT acc;
    byteT sh;
    acc = '0;
    sh  = a;
    for (int k = 0; k < ByteW; k++) begin
      if (b[k]) acc = acc ^ sh;
      sh = gfDbl(sh);
    end
    return acc;
  endfunction

  // a^254 by repeated squaring; zero maps to zero
  function automatic byteT gfInv(input byteT a);
    byteT pw;
    byteT res;
    pw  = a;
    res = 8'h01;
    for (int k = 1; k < ByteW; k++) begin
      pw  = gfMul(pw, pw);
      res = gfMul(res, pw);
    end
    return res;
  endfunction

  function automatic byteT sbAffine(input byteT x);
    byteT o;
    for (int b = 0; b < ByteW; b++)
      o[b] = x[b] ^ x[(b+4)%ByteW] ^ x[(b+5)%ByteW] ^ x[(b+6)%ByteW]
           ^ x[(b+7)%ByteW] ^ AffConst[b];
    return o;
  endfunction

  function automatic byteT mixCoef(input int n);
    case (n)
      0, 1:    return 8'h02;
      2, 5:    return 8'h03;
      3:       return 8'h04;
      4, 6:    return 8'h05;
      default: return 8'h07;
    endcase
  endfunction

  function automatic colT mixCol(input colT a);
    colT o;
    for (int r = 0; r < RowCnt; r++) begin
      o[r] = '0;
      for (int k = 0; k < RowCnt; k++)
        o[r] = o[r] ^ gfMul(mixCoef((k - r + RowCnt) % RowCnt), a[k]);
    end
    return o;
  endfunction
endpackage

// File: rtl/gst_stage1.sv
// Front half: round constant on column 0, then byte-wise field inversion.
module gst_stage1
  import gst_pkg::*;
(
  input  colT  colIn,
  input  logic isQ,
  input  logic firstCol,
  input  byteT rnd,
  output colT  colOut
);
  for (genvar i = 0; i < RowCnt; i++) begin : g_row
    logic hitP;
    logic hitQ;
    byteT keyed;
    assign hitP   = firstCol && !isQ && (i == 0);
    assign hitQ   = firstCol &&  isQ && (i == RowCnt - 1);
    assign keyed  = colIn[i] ^ (hitP ? rnd : '0) ^ (hitQ ? ~rnd : '0);
    assign colOut[i] = gfInv(keyed);
  end
endmodule

// File: rtl/gst_stage2.sv
// Back half: affine part of the S-box, then column mixing.
module gst_stage2
  import gst_pkg::*;
(
  input  colT colIn,
  output colT colOut
);
  colT subbed;
  for (genvar i = 0; i < RowCnt; i++) begin : g_row
    assign subbed[i] = sbAffine(colIn[i]);
  end
  assign colOut = mixCol(subbed);
endmodule

// File: rtl/gst_dp.sv
module gst_dp
  import gst_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  ctlT             ctl,
  input  logic [BlkW-1:0] pIn,
  input  logic [BlkW-1:0] qIn,
  output logic [BlkW-1:0] pOut,
  output logic [BlkW-1:0] qOut
);
  blkT pReg;
  blkT qReg;
  logic [0:ColCnt-2][0:RowCnt-1][ByteW-1:0] oBuf;

  blkT  s1Src;
  blkT  s2Src;
  blkT  commitBlk;
  colT  s1In;
  colT  s1Res;
  colT  s2In;
  colT  s2Res;
  logic lastCol;

  assign s1Src   = ctl.s1Q ? qReg : pReg;
  assign s2Src   = ctl.s2Q ? qReg : pReg;
  assign s1In    = s1Src[ctl.col];
  assign lastCol = (ctl.col == ColIdxW'(ColCnt - 1));

  // row shift as diagonal gather over the whole block
  for (genvar r = 0; r < RowCnt; r++) begin : g_diag
    logic [ColIdxW-1:0] srcCol;
    assign srcCol   = ColIdxW'(ctl.col + ColIdxW'(r));
    assign s2In[r]  = s2Src[srcCol][r];
  end

  gst_stage1 u_s1 (
    .colIn    (s1In),
    .isQ      (ctl.s1Q),
    .firstCol (ctl.col == '0),
    .rnd      (ctl.rnd),
    .colOut   (s1Res)
  );

  gst_stage2 u_s2 (
    .colIn  (s2In),
    .colOut (s2Res)
  );

  assign commitBlk = {oBuf, s2Res};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pReg <= '0;
      qReg <= '0;
      oBuf <= '0;
    end else if (ctl.load) begin
      pReg <= pIn;
      qReg <= qIn;
    end else begin
      if (ctl.s1En) begin
        if (ctl.s1Q) qReg[ctl.col] <= s1Res;
        else         pReg[ctl.col] <= s1Res;
      end
      if (ctl.s2En) begin
        oBuf <= {oBuf[1:ColCnt-2], s2Res};
        if (lastCol) begin
          if (ctl.s2Q) qReg <= commitBlk;
          else         pReg <= commitBlk;
        end
      end
    end
  end

  assign pOut = pReg;
  assign qOut = qReg;
endmodule

// File: rtl/gst_ctrl.sv
module gst_ctrl
  import gst_pkg::*;
#(
  parameter int ROUNDS = 10
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  output ctlT  ctl,
  output logic done
);
  localparam int LastSlot = 2 * ROUNDS;
  localparam int SlotW    = $clog2(LastSlot + 1);

  typedef enum logic {Idle, Run} stT;

  stT                 st;
  logic [SlotW-1:0]   slot;
  logic [ColIdxW-1:0] colCnt;
  logic               lastCol;
  logic               lastSlot;

  assign lastCol  = (colCnt == ColIdxW'(ColCnt - 1));
  assign lastSlot = (slot == SlotW'(LastSlot));

  always_comb begin
    ctl.load = (st == Idle) && start;
    ctl.s1En = (st == Run) && !lastSlot;
    ctl.s1Q  = slot[0];
    ctl.rnd  = ByteW'(slot >> 1);
    ctl.s2En = (st == Run) && (slot != '0);
    ctl.s2Q  = ~slot[0];
    ctl.col  = colCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st     <= Idle;
      slot   <= '0;
      colCnt <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        Idle: if (start) begin
          st     <= Run;
          slot   <= '0;
          colCnt <= '0;
        end
        default: begin
          colCnt <= colCnt + 1'b1;
          if (lastCol) begin
            if (lastSlot) begin
              st   <= Idle;
              done <= 1'b1;
            end else begin
              slot <= slot + 1'b1;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/gst_perm.sv
module gst_perm
  import gst_pkg::*;
#(
  parameter int ROUNDS = 10
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [BlkW-1:0] pIn,
  input  logic [BlkW-1:0] qIn,
  output logic [BlkW-1:0] pOut,
  output logic [BlkW-1:0] qOut,
  output logic            done
);
  ctlT ctl;

  gst_ctrl #(.ROUNDS(ROUNDS)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .ctl   (ctl),
    .done  (done)
  );

  gst_dp u_dp (
    .clk  (clk),
    .rstN (rstN),
    .ctl  (ctl),
    .pIn  (pIn),
    .qIn  (qIn),
    .pOut (pOut),
    .qOut (qOut)
  );
endmodule

// File: rtl/gst_perm_chk.sv
module gst_perm_chk
  import gst_pkg::*;
#(
  parameter int ROUNDS = 10
) (
  input logic            clk,
  input logic            rstN,
  input logic            start,
  input logic            done,
  input logic [BlkW-1:0] pOut,
  input logic [BlkW-1:0] qOut,
  input ctlT             ctl
);
  localparam int Lat  = (2 * ROUNDS + 1) * ColCnt;
  localparam int CntW = $clog2(Lat + 1);

  logic            act;
  logic [CntW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      act <= 1'b0;
      cnt <= '0;
    end else if (!act && start) begin
      act <= 1'b1;
      cnt <= '0;
    end else if (act) begin
      cnt <= cnt + 1'b1;
      if (cnt == CntW'(Lat - 1)) act <= 1'b0;
    end
  end

  always @(negedge clk) begin
    if (!rstN) begin
      a_r1_reset_clear: assert (!done && pOut == '0 && qOut == '0);
    end
  end

  a_r2_halves_disjoint: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.s1En && ctl.s2En) |-> (ctl.s1Q != ctl.s2Q));

  a_r4_done_latency: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (cnt == CntW'(Lat)));

  a_r4_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r5_outputs_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!act && !start) |=> ($stable(pOut) && $stable(qOut)));

  a_r6_no_done_midrun: assert property (@(posedge clk) disable iff (!rstN)
    act |-> !done);

  a_r6_load_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |-> !act);
endmodule

bind gst_perm gst_perm_chk #(.ROUNDS(ROUNDS)) u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .start (start),
  .done  (done),
  .pOut  (pOut),
  .qOut  (qOut),
  .ctl   (ctl)
);

// File: tb/gst_perm_tb.sv
module gst_perm_tb;
  localparam int ROUNDS = 10;
  localparam int LAT    = (2 * ROUNDS + 1) * 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [511:0] pIn = '0;
  logic [511:0] qIn = '0;
  logic [511:0] pOut;
  logic [511:0] qOut;
  logic         done;

  int total = 0;
  int bad   = 0;

  logic [7:0] sbox [256];
  localparam logic [7:0] COEF [8] = '{8'h02, 8'h02, 8'h03, 8'h04, 8'h05, 8'h03, 8'h05, 8'h07};

  always #4 clk = ~clk;

  gst_perm #(.ROUNDS(ROUNDS)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .pIn(pIn), .qIn(qIn),
    .pOut(pOut), .qOut(qOut), .done(done)
  );

  function automatic logic [7:0] fmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r;
    logic [7:0] s;
    r = '0;
    s = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) r ^= s;
      s = {s[6:0], 1'b0} ^ (s[7] ? 8'h1b : 8'h00);
    end
    return r;
  endfunction

  function automatic logic [7:0] rol8(input logic [7:0] x, input int k);
    return (x << k) | (x >> (8 - k));
  endfunction

  function automatic logic [511:0] refPerm(input logic [511:0] x, input bit isQ);
    logic [7:0] m [8][8];
    logic [7:0] t [8][8];
    logic [7:0] acc;
    logic [511:0] y;
    for (int c = 0; c < 8; c++)
      for (int r = 0; r < 8; r++)
        m[r][c] = x[511 - 8*(8*c + r) -: 8];
    for (int rd = 0; rd < ROUNDS; rd++) begin
      if (!isQ) m[0][0] ^= 8'(rd);
      else      m[7][0] ^= 8'(rd) ^ 8'hff;
      for (int r = 0; r < 8; r++)
        for (int c = 0; c < 8; c++)
          m[r][c] = sbox[m[r][c]];
      for (int r = 0; r < 8; r++)
        for (int c = 0; c < 8; c++)
          t[r][c] = m[r][(c + r) % 8];
      for (int c = 0; c < 8; c++)
        for (int r = 0; r < 8; r++) begin
          acc = '0;
          for (int k = 0; k < 8; k++)
            acc ^= fmul(COEF[(k - r + 8) % 8], t[k][c]);
          m[r][c] = acc;
        end
    end
    for (int c = 0; c < 8; c++)
      for (int r = 0; r < 8; r++)
        y[511 - 8*(8*c + r) -: 8] = m[r][c];
    return y;
  endfunction

  function automatic logic [511:0] rampBytes(input logic [7:0] base, input logic [7:0] step);
    logic [511:0] v;
    for (int k = 0; k < 64; k++) v[511 - 8*k -: 8] = base + 8'(k) * step;
    return v;
  endfunction

  function automatic logic [511:0] xsFill(input logic [63:0] seed);
    logic [511:0] v;
    logic [63:0] s;
    s = seed;
    for (int k = 0; k < 8; k++) begin
      s ^= s << 13; s ^= s >> 7; s ^= s << 17;
      v[511 - 64*k -: 64] = s;
    end
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runOne(input logic [511:0] p, input logic [511:0] q,
                        input string tagP, input string tagQ, input string tagT,
                        input bit midStart, input bit hold, input bit noWait);
    logic [511:0] eP;
    logic [511:0] eQ;
    bit early;
    eP = refPerm(p, 1'b0);
    eQ = refPerm(q, 1'b1);
    early = 1'b0;
    if (!noWait) @(negedge clk);
    pIn = p; qIn = q; start = 1'b1;
    @(negedge clk);
    start = 1'b0; pIn = ~p; qIn = ~q;
    for (int k = 1; k <= LAT; k++) begin
      @(negedge clk);
      if (k < LAT && done) early = 1'b1;
      if (midStart && k == 60) begin start = 1'b1; pIn = q; qIn = p; end
      if (midStart && k == 61) start = 1'b0;
    end
    chk(done && !early, {tagT, " done timing"}, {510'b0, early, done}, 512'b1);
    chk(pOut == eP, {tagP, " P result"}, pOut, eP);
    chk(qOut == eQ, {tagQ, " Q result"}, qOut, eQ);
    if (hold) begin
      @(negedge clk);
      chk(!done, "R4 done single cycle", {511'b0, done}, 512'b0);
      pIn = xsFill(64'h1234); qIn = xsFill(64'h9876);
      repeat (4) @(negedge clk);
      chk(pOut == eP && qOut == eQ, "R5 outputs hold", pOut ^ qOut, eP ^ eQ);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] inv;
    for (int a = 0; a < 256; a++) begin
      inv = '0;
      for (int b = 1; b < 256; b++)
        if (fmul(8'(a), 8'(b)) == 8'h01) inv = 8'(b);
      sbox[a] = inv ^ rol8(inv, 1) ^ rol8(inv, 2) ^ rol8(inv, 3) ^ rol8(inv, 4) ^ 8'h63;
    end
    // model sanity on known S-box points (R2)
    chk(sbox[0] == 8'h63 && sbox[8'h53] == 8'hed && sbox[1] == 8'h7c, "R2 sbox model",
        {488'b0, sbox[0], sbox[8'h53], sbox[1]}, {488'b0, 24'h63ed7c});

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!done, "R1 done in reset", {511'b0, done}, 512'b0);
    chk(pOut == '0, "R1 pOut in reset", pOut, '0);
    chk(qOut == '0, "R1 qOut in reset", qOut, '0);
    rstN = 1'b1;

    // R2/R3 under several patterns
    runOne('0, '0, "R2", "R3", "R4", 1'b0, 1'b1, 1'b0);
    runOne('1, '1, "R2", "R3", "R4", 1'b0, 1'b1, 1'b0);
    runOne(rampBytes(8'h00, 8'h01), rampBytes(8'hff, 8'hff), "R2", "R3", "R4", 1'b0, 1'b1, 1'b0);
    runOne(xsFill(64'hdead_beef_0bad_f00d), xsFill(64'h0123_4567_89ab_cdef),
           "R2", "R3", "R4", 1'b0, 1'b1, 1'b0);
    runOne({1'b1, 511'b0}, {511'b0, 1'b1}, "R2", "R3", "R4", 1'b0, 1'b1, 1'b0);

    // R6: start mid-run ignored
    runOne(xsFill(64'h5555), xsFill(64'haaaa), "R6", "R6", "R6", 1'b1, 1'b1, 1'b0);

    // R7: back-to-back, second start in the done cycle
    runOne(xsFill(64'h77), xsFill(64'h88), "R2", "R3", "R4", 1'b0, 1'b0, 1'b0);
    runOne(rampBytes(8'h10, 8'h03), xsFill(64'h99), "R7", "R7", "R7", 1'b0, 1'b1, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule